// File: doc/BRIEF.md
# Sectored Direct-Mapped Data Cache

This block is a direct-mapped, write-back, write-allocate cache whose lines are divided into subblocks. A single address tag serves a whole line. Each subblock keeps its own presence flag and its own modified flag. All traffic to the next memory level moves exactly one subblock per transaction. A miss never loads a full line. It loads only the subblock that holds the requested word. This keeps refill bandwidth low and still spends one tag per line.

A processor presents a word address with a read or write strobe and holds it there. On a hit the cache answers in the same cycle. On a miss the cache keeps `cpu_ready` low while it runs the miss sequence:

1. If the tag must change, every modified subblock of the victim line is written back, one transaction each, lowest subblock first.
2. The tag is then replaced and the other subblocks of that line are marked absent.
3. The requested subblock is fetched.

When the sequence ends, the held access completes as an ordinary hit. Addresses are word addresses. The lowest bits pick the word inside a subblock. The bits above them select the subblock, then the line index, and the top bits form the tag.

Top module: `sc_cache`

## Requirements
- R1: After reset, every subblock is absent and clean, so the first access to any address is a miss that performs exactly one subblock read and no write-back.
- R2: An access whose tag matches and whose subblock is present raises `cpu_ready` in the same cycle as the request. It causes no memory traffic. A read returns the most recently written value of that word.
- R3: A miss whose tag matches a line that holds at least one present subblock keeps the tag. It reads only the addressed subblock, at `mem_addr` equal to `cpu_addr` with its word-offset bits (bits [1:0]) cleared, and leaves the other subblocks of the line untouched.
- R4: A miss that needs a different tag replaces the line's tag and marks every other subblock of that line absent. A later access to any of them under either tag is therefore a miss.
- R5: Before a tag replacement, each modified subblock of the victim line is written back in its own transaction. The order is ascending subblock index. Each write carries the victim's tag and line index and the subblock's current data. The fetch is issued only after the last write.
- R6: A write hit updates only the addressed word and marks its subblock modified. A write miss first fetches the subblock, then applies the write.
- R7: `cpu_ready` stays low whenever a memory transaction is outstanding. It is high only while a request is present.
- R8: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the start of a transaction until the cycle in which `mem_ack` is seen. Word i of a subblock travels in data bits [32*i+31 : 32*i].
- R9: Subblocks that are present but unmodified are never written back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | WORD_W | Write data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Subblock transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | ADDR_W | Subblock-aligned word address |
| mem_wdata | output | WPS*WORD_W | Write-back data for one subblock |
| mem_ack | input | 1 | One-cycle completion of the current transaction |
| mem_rdata | input | WPS*WORD_W | Fetched subblock data, valid with `mem_ack` |

## Verification
Several properties are checked every cycle at the ports:
- the memory-side signals stay steady while a transaction waits for its acknowledge;
- fetches target exactly the requested subblock;
- write-backs stay on the requested line;
- the processor is never released while a transaction is open.

Other behaviour only the bench scenarios can show: which subblocks get written back and in what order, that clean subblocks are skipped, that a tag change wipes the sibling subblocks, and that data survives write-back and refill. The bench's behavioural model predicts the exact transaction list and data for every access and compares them.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_DRAIN = 2'd1,
    SC_FETCH = 2'd2
  } sc_state_e;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  assign sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/sc_pick.sv
module sc_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/sc_store.sv
module sc_store #(
  parameter int LINES  = 16,
  parameter int SUBS   = 4,
  parameter int WPS    = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int SEL_W = $clog2(SUBS),
  localparam int OFF_W = $clog2(WPS),
  localparam int BLK_W = WPS * WORD_W,
  localparam int LN_W  = SUBS * BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [SEL_W-1:0]  lk_sub,
  input  logic [OFF_W-1:0]  lk_off,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [SUBS-1:0]   lk_valid,
  output logic [SUBS-1:0]   lk_dirty,
  output logic [WORD_W-1:0] lk_word,
  input  logic [SEL_W-1:0]  wb_sub,
  output logic [BLK_W-1:0]  wb_data,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic [BLK_W-1:0]  fill_data,
  input  logic              clean_en,
  input  logic              retag_en,
  input  logic [TAG_W-1:0]  retag_tag
);
  logic [LINES*SUBS-1:0]  valid_flat;
  logic [LINES*SUBS-1:0]  dirty_flat;
  logic [LINES*TAG_W-1:0] tag_flat;
  logic [LINES*LN_W-1:0]  data_flat;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic            sel;
    logic [SUBS-1:0] v_q, v_d, d_q, d_d;
    logic [TAG_W-1:0] t_q;
    logic [LN_W-1:0] ln_q, ln_d;
    logic            st_en, tg_en, ln_en;

    assign sel   = (lk_idx == IDX_W'(l));
    assign st_en = sel && (retag_en || fill_en || wr_en || clean_en);
    assign tg_en = sel && retag_en;
    assign ln_en = sel && (fill_en || wr_en);

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      if (retag_en) begin
        v_d = '0;
        d_d = '0;
      end
      if (fill_en) begin
        v_d[lk_sub] = 1'b1;
        d_d[lk_sub] = 1'b0;
      end
      if (wr_en)    d_d[lk_sub] = 1'b1;
      if (clean_en) d_d[wb_sub] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        d_q <= '0;
      end else if (st_en) begin
        v_q <= v_d;
        d_q <= d_d;
      end
    end

    always_ff @(posedge clk) begin
      if (tg_en) t_q <= retag_tag;
    end

    always_comb begin
      ln_d = ln_q;
      if (fill_en)
        ln_d[int'(lk_sub)*BLK_W +: BLK_W] = fill_data;
      if (wr_en)
        ln_d[int'(lk_sub)*BLK_W + int'(lk_off)*WORD_W +: WORD_W] = wr_data;
    end

    always_ff @(posedge clk) begin
      if (ln_en) ln_q <= ln_d;
    end

    assign valid_flat[l*SUBS +: SUBS]   = v_q;
    assign dirty_flat[l*SUBS +: SUBS]   = d_q;
    assign tag_flat[l*TAG_W +: TAG_W]   = t_q;
    assign data_flat[l*LN_W +: LN_W]    = ln_q;
  end

  assign lk_valid = valid_flat[int'(lk_idx)*SUBS +: SUBS];
  assign lk_dirty = dirty_flat[int'(lk_idx)*SUBS +: SUBS];
  assign lk_tag   = tag_flat[int'(lk_idx)*TAG_W +: TAG_W];
  assign lk_word  = data_flat[int'(lk_idx)*LN_W + int'(lk_sub)*BLK_W
                              + int'(lk_off)*WORD_W +: WORD_W];
  assign wb_data  = data_flat[int'(lk_idx)*LN_W + int'(wb_sub)*BLK_W +: BLK_W];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic hit,
  input  logic tag_eq,
  input  logic line_live,
  input  logic dirty_any,
  input  logic mem_ack,
  output logic cpu_ready,
  output logic mem_req,
  output logic mem_we,
  output logic wr_en,
  output logic fill_en,
  output logic clean_en,
  output logic retag_en
);
  sc_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    wr_en     = 1'b0;
    fill_en   = 1'b0;
    clean_en  = 1'b0;
    retag_en  = 1'b0;
    unique case (st_q)
      SC_IDLE: begin
        if (cpu_req) begin
          if (hit) begin
            cpu_ready = 1'b1;
            wr_en     = cpu_we;
          end else if (tag_eq && line_live) begin
            st_d = SC_FETCH;
          end else if (dirty_any) begin
            st_d = SC_DRAIN;
          end else begin
            retag_en = 1'b1;
            st_d     = SC_FETCH;
          end
        end
      end
      SC_DRAIN: begin
        if (dirty_any) begin
          mem_req  = 1'b1;
          mem_we   = 1'b1;
          clean_en = mem_ack;
        end else begin
          retag_en = 1'b1;
          st_d     = SC_FETCH;
        end
      end
      SC_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          st_d    = SC_IDLE;
        end
      end
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SC_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/sc_cache.sv
module sc_cache #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int WPS    = 4,
  parameter int SUBS   = 4,
  parameter int LINES  = 16,
  localparam int OFF_W = $clog2(WPS),
  localparam int SEL_W = $clog2(SUBS),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - SEL_W - IDX_W,
  localparam int BLK_W = WPS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_rdata
);
  logic             rst_sync_n;
  logic [OFF_W-1:0] a_off;
  logic [SEL_W-1:0] a_sub;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic [TAG_W-1:0] lk_tag;
  logic [SUBS-1:0]  lk_valid, lk_dirty;
  logic [SEL_W-1:0] wb_sub;
  logic             dirty_any, tag_eq, line_live, hit;
  logic             wr_en, fill_en, clean_en, retag_en;

  assign {a_tag, a_idx, a_sub, a_off} = cpu_addr;

  sc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sc_store #(
    .LINES (LINES), .SUBS (SUBS), .WPS (WPS), .WORD_W (WORD_W), .TAG_W (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lk_idx    (a_idx),
    .lk_sub    (a_sub),
    .lk_off    (a_off),
    .lk_tag    (lk_tag),
    .lk_valid  (lk_valid),
    .lk_dirty  (lk_dirty),
    .lk_word   (cpu_rdata),
    .wb_sub    (wb_sub),
    .wb_data   (mem_wdata),
    .wr_en     (wr_en),
    .wr_data   (cpu_wdata),
    .fill_en   (fill_en),
    .fill_data (mem_rdata),
    .clean_en  (clean_en),
    .retag_en  (retag_en),
    .retag_tag (a_tag)
  );

  sc_pick #(.N (SUBS)) u_pick (
    .req (lk_dirty),
    .any (dirty_any),
    .idx (wb_sub)
  );

  assign tag_eq    = (lk_tag == a_tag);
  assign line_live = |lk_valid;
  assign hit       = tag_eq && lk_valid[a_sub];

  sc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .hit       (hit),
    .tag_eq    (tag_eq),
    .line_live (line_live),
    .dirty_any (dirty_any),
    .mem_ack   (mem_ack),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .wr_en     (wr_en),
    .fill_en   (fill_en),
    .clean_en  (clean_en),
    .retag_en  (retag_en)
  );

  assign mem_addr = mem_we ? {lk_tag, a_idx, wb_sub, {OFF_W{1'b0}}}
                           : {a_tag,  a_idx, a_sub,  {OFF_W{1'b0}}};
endmodule

// File: rtl/sc_cache_chk.sv
module sc_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int WPS    = 4,
  parameter int SUBS   = 4,
  parameter int BLK_W  = 128,
  localparam int OFF_W = $clog2(WPS),
  localparam int LOW_W = $clog2(WPS) + $clog2(SUBS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BLK_W-1:0]  mem_wdata,
  input logic              mem_ack
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> $stable(mem_wdata));

  p_ready_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  p_no_ready_in_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  p_fetch_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |->
      mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]);

  p_wb_same_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |->
      mem_addr[ADDR_W-1-(ADDR_W-LOW_W-4) -: 4] ==
      cpu_addr[ADDR_W-1-(ADDR_W-LOW_W-4) -: 4]);

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[OFF_W-1:0] == '0);
endmodule

bind sc_cache sc_cache_chk #(
  .ADDR_W (ADDR_W), .WPS (WPS), .SUBS (SUBS), .BLK_W (BLK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_addr  (cpu_addr),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/sc_cache_tb.sv
module sc_cache_tb_top;
  localparam int CLK_P = 10;
  localparam int LAT   = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_req, cpu_we;
  logic [15:0]  cpu_addr;
  logic [31:0]  cpu_wdata;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack;
  logic [127:0] mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_P/2) clk = ~clk;

  sc_cache dut_i (
    .clk (clk), .rst_n (rst_n),
    .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_ready (cpu_ready), .cpu_rdata (cpu_rdata),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
  );

  // architectural and backing memory (word addressed)
  logic [31:0] gold [int];
  logic [31:0] bmem [int];
  // behavioural cache state
  int m_tag [16];
  bit m_val [16][4];
  bit m_dty [16][4];
  // observed transactions
  int log_a [$];
  bit log_w [$];

  function automatic logic [31:0] seed_val(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] gold_rd(int a);
    return gold.exists(a) ? gold[a] : seed_val(a);
  endfunction
  function automatic logic [31:0] bmem_rd(int a);
    return bmem.exists(a) ? bmem[a] : seed_val(a);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // next-level memory responder
  initial begin
    int cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req === 1'b1) begin
        cnt++;
        if (cnt == LAT) begin
          cnt = 0;
          mem_ack = 1'b1;
          log_a.push_back(int'(mem_addr));
          log_w.push_back(mem_we);
          for (int w = 0; w < 4; w++) begin
            if (mem_we) begin
              check(mem_wdata[32*w +: 32] == gold_rd(int'(mem_addr) + w), "R5",
                    "write-back word", mem_wdata[32*w +: 32], gold_rd(int'(mem_addr) + w));
              bmem[int'(mem_addr) + w] = mem_wdata[32*w +: 32];
            end else begin
              mem_rdata[32*w +: 32] = bmem_rd(int'(mem_addr) + w);
            end
          end
        end
      end else cnt = 0;
    end
  end

  task automatic access(bit we, int addr, logic [31:0] wd);
    int idx = (addr >> 4) & 15;
    int sub = (addr >> 2) & 3;
    int tg  = (addr >> 8) & 255;
    bit hit, live, any_wb;
    int exp_a [$];
    bit exp_w [$];
    int waited = 0;
    logic [31:0] got;
    string rq;
    live = 0;
    for (int s = 0; s < 4; s++) live |= m_val[idx][s];
    hit = m_val[idx][sub] && (m_tag[idx] == tg);
    any_wb = 0;
    if (!hit) begin
      if (!(m_tag[idx] == tg && live)) begin
        for (int s = 0; s < 4; s++) begin
          if (m_dty[idx][s]) begin
            exp_a.push_back((m_tag[idx] << 8) | (idx << 4) | (s << 2));
            exp_w.push_back(1'b1);
            any_wb = 1;
          end
          m_val[idx][s] = 0;
          m_dty[idx][s] = 0;
        end
        m_tag[idx] = tg;
      end
      exp_a.push_back(addr & ~3);
      exp_w.push_back(1'b0);
      m_val[idx][sub] = 1;
    end
    if (we) m_dty[idx][sub] = 1;
    log_a.delete();
    log_w.delete();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = 16'(addr); cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_ready === 1'b1) break;
      @(negedge clk);
      waited++;
    end
    got = cpu_rdata;
    @(posedge clk);
    #1 cpu_req = 1'b0;
    rq = hit ? "R2" : "R7";
    check(hit ? (waited == 0) : (waited > 0), rq, "ready delay", waited, hit ? 0 : 1);
    if (!we) check(got == gold_rd(addr), we ? "R6" : (hit ? "R2" : "R3"),
                   "read data", got, gold_rd(addr));
    else gold[addr] = wd;
    rq = any_wb ? "R5" : (hit ? "R2" : "R3");
    check(log_a.size() == exp_a.size(), rq, "transaction count", log_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < log_a.size(); i++) begin
      check(log_a[i] == exp_a[i] && log_w[i] == exp_w[i], rq, "transaction addr/we",
            (log_a[i] << 1) | log_w[i], (exp_a[i] << 1) | exp_w[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 16; l++) begin
      m_tag[l] = -1;
      for (int s = 0; s < 4; s++) begin m_val[l][s] = 0; m_dty[l][s] = 0; end
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check(cpu_ready == 1'b0, "R1", "ready in reset", cpu_ready, 0);
    check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(mem_req == 1'b0 && cpu_ready == 1'b0, "R1", "idle after reset",
          {mem_req, cpu_ready}, 0);

    access(0, 'h1231, 0);            // R1: cold miss, single fetch
    access(0, 'h1232, 0);            // R2: hit
    access(0, 'h1235, 0);            // R3: same tag, other subblock
    access(0, 'h1231, 0);            // R3: first subblock kept
    access(1, 'h1236, 32'hCAFE0001); // R6: write hit
    access(0, 'h1236, 0);            // R6: read back
    access(0, 'h1237, 0);            // R6: neighbour word unchanged
    access(1, 'h123A, 32'hBEEF0002); // R6: write miss allocates
    access(0, 'h4530, 0);            // R5 / R9: two write-backs, clean skipped
    access(0, 'h4534, 0);            // R4: sibling under new tag invalidated
    access(0, 'h1236, 0);            // R4: old tag gone, data from memory
    access(0, 'h123A, 0);            // R4: old-tag sibling miss

    for (int k = 0; k < 500; k++) begin
      int a = ($urandom_range(1, 3) << 8) | ($urandom_range(0, 3) << 4)
            | $urandom_range(0, 15);
      access($urandom_range(0, 1) == 1, a, $urandom);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule